// File: doc/BRIEF.md
# Select-Gated Two-Wire Register Slave

This block is a two-wire serial (I2C-style) slave. It gives a host read and write access to a small register map that lives outside the block. SCL, SDA and an active-low module-select input are each passed through a two-flop synchronizer. All three are then sampled on the system clock, which must run at least eight times faster than SCL. SDA is open-drain: the block only pulls the line low through `sda_oe_o` and otherwise leaves it released.

A host writes by sending the device address, then a one-byte register pointer, then any number of data bytes. Each data byte lands at the pointer, and the pointer then steps by one. A host reads by first setting the pointer in a write, then issuing a repeated START and the read address. The slave then streams bytes from the pointer until the host answers a byte with NACK. Several modules can share one bus because each slave answers only while its own select input is held low. When select rises, the slave drops whatever it was doing.

Top module: `twi_sel_slave`

## Requirements
- R1: After reset `sda_oe_o` and `reg_we_o` are both 0.
- R2: While select is low, an address byte whose upper seven bits equal `DEV_ADDR` is acknowledged: SDA is held low through the ninth SCL pulse.
- R3: An address byte that does not match is not acknowledged. No later byte is acknowledged and no register is written until the next START.
- R4: While `sel_ni` is high the slave acknowledges nothing and writes nothing, even when the bus address matches.
- R5: In a write (address bit 0 = 0), the first byte after the address loads the pointer. Each further byte gives one single-cycle `reg_we_o` pulse with `reg_addr_o` equal to the pointer and `reg_wdata_o` equal to the byte. The pointer then increments, and every such byte is acknowledged.
- R6: In a read (address bit 0 = 1), the slave shifts out the byte at `reg_addr_o`, MSB first, and increments the pointer. It carries on with the next byte for as long as the host acknowledges.
- R7: The slave pulls SDA low only in the acknowledge slot of a byte it accepts, and for the zero bits of read data. After a host NACK it keeps SDA released.
- R8: A repeated START restarts address decoding without a STOP in between, and the pointer is kept across it.
- R9: If `sel_ni` rises in the middle of a transfer, SDA is released within 4 system clocks. The slave then ignores the rest of the traffic until a START seen while selected.
- R10: The pointer is 8 bits wide and wraps from 0xFF to 0x00, for both writes and reads.
- R11: While selected, the slave changes `sda_oe_o` only while SCL is low, so it never creates a START or a STOP itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x the SCL rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases the line |
| sel_ni | input | 1 | Active-low module select |
| reg_rdata_i | input | 8 | Register-file read data for `reg_addr_o` |
| reg_we_o | output | 1 | Single-cycle register write strobe |
| reg_addr_o | output | AW | Current register pointer |
| reg_wdata_o | output | 8 | Write data, valid with `reg_we_o` |

## Verification
Two of the block's functions can fall in the same cycle: deselection and the SCL falling edge on which the slave would put out its next read bit. The bench provokes this by raising `sel_ni` just after SCL falls in the middle of a read byte. Deselection must win. SDA must be released within the R9 bound and stay released through the rest of that byte, its acknowledge slot and a following host byte, with no write strobe. A fresh START after reselection must then be acknowledged again. The same kind of collision is exercised at the register-file port, where the write strobe and the pointer step fall on adjacent cycles across the 0xFF to 0x00 wrap.

// File: rtl/twi_sel_pkg.sv
package twi_sel_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK
  } twi_state_e;

  typedef enum logic [1:0] {
    K_ADDR,
    K_PTR,
    K_DATA
  } rx_kind_e;
endpackage

// File: rtl/twi_sel_sync.sv
module twi_sel_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  input  logic sel_ni,
  output logic scl_o,
  output logic scl_prev_o,
  output logic sda_o,
  output logic desel_o,
  output logic start_o,
  output logic stop_o
);
  localparam int W = 3;

  logic [STAGES-1:0][W-1:0] stage_q;
  logic scl_p_q, sda_p_q;

  // lines idle high; select idles deselected
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '1;
      scl_p_q <= 1'b1;
      sda_p_q <= 1'b1;
    end else begin
      stage_q[0] <= {sel_ni, sda_i, scl_i};
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
      scl_p_q <= stage_q[STAGES-1][0];
      sda_p_q <= stage_q[STAGES-1][1];
    end
  end

  assign scl_o      = stage_q[STAGES-1][0];
  assign sda_o      = stage_q[STAGES-1][1];
  assign desel_o    = stage_q[STAGES-1][2];
  assign scl_prev_o = scl_p_q;
  assign start_o    = scl_o & scl_p_q & sda_p_q & ~sda_o;
  assign stop_o     = scl_o & scl_p_q & ~sda_p_q & sda_o;
endmodule

// File: rtl/twi_sel_engine.sv
module twi_sel_engine
  import twi_sel_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h50,
  parameter int         AW       = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              scl_prev_i,
  input  logic              sda_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              desel_i,
  input  logic [BYTE_W-1:0] rdata_i,
  output logic              sda_oe_o,
  output logic              we_o,
  output logic [AW-1:0]     addr_o,
  output logic [BYTE_W-1:0] wdata_o
);
  localparam int CW = $clog2(BYTE_W + 1);
  localparam logic [CW-1:0] LAST_RX = CW'(BYTE_W);
  localparam logic [CW-1:0] LAST_TX = CW'(BYTE_W - 1);

  twi_state_e        st_q;
  rx_kind_e          kind_q;
  logic [CW-1:0]     cnt_q;
  logic [BYTE_W-1:0] sh_q;
  logic [BYTE_W-1:0] wdata_q;
  logic [AW-1:0]     ptr_q;
  logic              rd_q, mack_q, we_q, oe_q;
  logic              scl_rise, scl_fall;

  assign scl_rise = scl_i & ~scl_prev_i;
  assign scl_fall = ~scl_i & scl_prev_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      kind_q  <= K_ADDR;
      cnt_q   <= '0;
      sh_q    <= '0;
      wdata_q <= '0;
      ptr_q   <= '0;
      rd_q    <= 1'b0;
      mack_q  <= 1'b0;
      we_q    <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      we_q <= 1'b0;
      // pointer steps the cycle after the strobe so the address is stable during it
      if (we_q) ptr_q <= ptr_q + AW'(1);
      if (desel_i) begin
        st_q <= ST_IDLE;
        oe_q <= 1'b0;
      end else if (start_i) begin
        st_q   <= ST_RX;
        kind_q <= K_ADDR;
        cnt_q  <= '0;
        oe_q   <= 1'b0;
      end else if (stop_i) begin
        st_q <= ST_IDLE;
        oe_q <= 1'b0;
      end else begin
        unique case (st_q)
          ST_RX: begin
            if (scl_rise && cnt_q != LAST_RX) begin
              sh_q  <= {sh_q[BYTE_W-2:0], sda_i};
              cnt_q <= cnt_q + CW'(1);
            end else if (scl_fall && cnt_q == LAST_RX) begin
              unique case (kind_q)
                K_ADDR: begin
                  if (sh_q[BYTE_W-1:1] == DEV_ADDR) begin
                    rd_q <= sh_q[0];
                    oe_q <= 1'b1;
                    st_q <= ST_ACK;
                  end else begin
                    st_q <= ST_IDLE;
                  end
                end
                K_PTR: begin
                  ptr_q <= AW'(sh_q);
                  oe_q  <= 1'b1;
                  st_q  <= ST_ACK;
                end
                default: begin
                  we_q    <= 1'b1;
                  wdata_q <= sh_q;
                  oe_q    <= 1'b1;
                  st_q    <= ST_ACK;
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              cnt_q <= '0;
              if (kind_q == K_ADDR && rd_q) begin
                sh_q  <= rdata_i;
                ptr_q <= ptr_q + AW'(1);
                oe_q  <= ~rdata_i[BYTE_W-1];
                st_q  <= ST_TX;
              end else begin
                oe_q   <= 1'b0;
                kind_q <= (kind_q == K_ADDR) ? K_PTR : K_DATA;
                st_q   <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (cnt_q == LAST_TX) begin
                oe_q <= 1'b0;
                st_q <= ST_MACK;
              end else begin
                sh_q  <= {sh_q[BYTE_W-2:0], 1'b0};
                oe_q  <= ~sh_q[BYTE_W-2];
                cnt_q <= cnt_q + CW'(1);
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              mack_q <= ~sda_i;
            end else if (scl_fall) begin
              if (mack_q) begin
                sh_q  <= rdata_i;
                ptr_q <= ptr_q + AW'(1);
                oe_q  <= ~rdata_i[BYTE_W-1];
                cnt_q <= '0;
                st_q  <= ST_TX;
              end else begin
                st_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o = oe_q;
  assign we_o     = we_q;
  assign addr_o   = ptr_q;
  assign wdata_o  = wdata_q;
endmodule

// File: rtl/twi_sel_slave.sv
module twi_sel_slave
  import twi_sel_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h50,
  parameter int         AW          = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic              sel_ni,
  input  logic [BYTE_W-1:0] reg_rdata_i,
  output logic              reg_we_o,
  output logic [AW-1:0]     reg_addr_o,
  output logic [BYTE_W-1:0] reg_wdata_o
);
  logic scl_s, scl_p, sda_s, desel_s, start_s, stop_s;

  twi_sel_sync #(
    .STAGES(SYNC_STAGES)
  ) i_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sel_ni    (sel_ni),
    .scl_o     (scl_s),
    .scl_prev_o(scl_p),
    .sda_o     (sda_s),
    .desel_o   (desel_s),
    .start_o   (start_s),
    .stop_o    (stop_s)
  );

  twi_sel_engine #(
    .DEV_ADDR(DEV_ADDR),
    .AW      (AW)
  ) i_engine (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_s),
    .scl_prev_i(scl_p),
    .sda_i     (sda_s),
    .start_i   (start_s),
    .stop_i    (stop_s),
    .desel_i   (desel_s),
    .rdata_i   (reg_rdata_i),
    .sda_oe_o  (sda_oe_o),
    .we_o      (reg_we_o),
    .addr_o    (reg_addr_o),
    .wdata_o   (reg_wdata_o)
  );
endmodule

// File: rtl/twi_sel_checker.sv
module twi_sel_checker #(
  parameter int AW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          desel_i,
  input logic          scl_i,
  input logic          sda_oe_i,
  input logic          we_i,
  input logic [AW-1:0] addr_i
);
  p_idle_reset_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !sda_oe_i && !we_i);

  p_we_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> !we_i);

  p_ptr_wrap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (addr_i == $past(addr_i) + AW'(1)));

  p_desel_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desel_i |=> !sda_oe_i);

  p_desel_no_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (desel_i && $past(desel_i)) |-> !we_i);

  p_sda_low_phase_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!desel_i && !$past(desel_i) && (sda_oe_i != $past(sda_oe_i))) |-> !$past(scl_i));
endmodule

bind twi_sel_slave twi_sel_checker #(
  .AW(AW)
) i_twi_sel_checker (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .desel_i (desel_s),
  .scl_i   (scl_s),
  .sda_oe_i(sda_oe_o),
  .we_i    (reg_we_o),
  .addr_i  (reg_addr_o)
);

// File: tb/test_twi_sel_slave.sv
module test_twi_sel_slave;
  localparam time CLK_PERIOD = 10ns;
  localparam int Q = 6;
  localparam logic [6:0] DEV = 7'h50;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1, sel_n = 1'b0;
  logic sda_oe, reg_we;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  wire  sda_line = sda_m & ~sda_oe;

  logic [7:0]  mem[256];
  logic [7:0]  ref_mem[256];
  logic [15:0] exp_wr[$];
  int    checks = 0, fails = 0, cyc = 0;
  logic  may_drive = 1'b0, done = 1'b0;
  string cur_req = "R5";

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign reg_rdata = mem[reg_addr];
  always @(posedge clk) if (reg_we) mem[reg_addr] <= reg_wdata;

  twi_sel_slave #(.DEV_ADDR(DEV)) i_twi_sel_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .sel_ni(sel_n), .reg_rdata_i(reg_rdata), .reg_we_o(reg_we),
    .reg_addr_o(reg_addr), .reg_wdata_o(reg_wdata)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  // per-clock reference comparison
  logic prev_oe = 1'b0, prev_scl = 1'b1;
  int   sel_quiet = 0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(!(sda_oe && !may_drive), "R7", "sda driven outside allowed slot", sda_oe, 0);
      if (sel_quiet >= 6 && scl && prev_scl)
        check(sda_oe == prev_oe, "R11", "sda changed while scl high", sda_oe, prev_oe);
      if (reg_we) begin
        if (exp_wr.size() == 0) check(1'b0, cur_req, "unexpected write", {reg_addr, reg_wdata}, 0);
        else begin
          logic [15:0] e;
          e = exp_wr.pop_front();
          check({reg_addr, reg_wdata} == e, "R5", "write addr/data", {reg_addr, reg_wdata}, e);
        end
      end
    end
    sel_quiet = sel_n ? 0 : sel_quiet + 1;
    prev_oe   = sda_oe;
    prev_scl  = scl;
  end

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic slot(input logic mb, input logic allow, output logic got);
    may_drive = may_drive | allow;
    wclk(Q);
    may_drive = allow;
    sda_m = mb;
    wclk(Q);
    scl = 1'b1;
    wclk(Q);
    got = sda_line;
    wclk(Q);
    scl = 1'b0;
  endtask

  task automatic do_start();
    wclk(Q); may_drive = 1'b0; sda_m = 1'b1;
    wclk(Q); scl = 1'b1;
    wclk(Q); sda_m = 1'b0;
    wclk(Q); scl = 1'b0;
  endtask

  task automatic do_stop();
    wclk(Q); may_drive = 1'b0; sda_m = 1'b0;
    wclk(Q); scl = 1'b1;
    wclk(Q); sda_m = 1'b1;
    wclk(2 * Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
    logic g;
    for (int i = 7; i >= 0; i--) slot(b[i], 1'b0, g);
    slot(1'b1, exp_ack, g);
    check((!g) == exp_ack, req, "ack of host byte", !g, exp_ack);
  endtask

  task automatic recv_byte(input logic [7:0] exp, input bit mack, input string req);
    logic [7:0] v;
    logic g;
    for (int i = 7; i >= 0; i--) begin
      slot(1'b1, 1'b1, g);
      v[i] = g;
    end
    slot(!mack, 1'b0, g);
    check(v == exp, req, "read byte", v, exp);
  endtask

  task automatic write_seq(input logic [7:0] ptr, input int n, input logic [7:0] base, input string req);
    int p;
    p = ptr;
    do_start();
    send_byte({DEV, 1'b0}, 1'b1, "R2");
    send_byte(ptr, 1'b1, req);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      d = base + 8'(i * 17);
      exp_wr.push_back({8'(p), d});
      ref_mem[p] = d;
      send_byte(d, 1'b1, req);
      p = (p + 1) % 256;
    end
    do_stop();
  endtask

  task automatic read_seq(input logic [7:0] ptr, input int n, input string req);
    int p;
    p = ptr;
    do_start();
    send_byte({DEV, 1'b0}, 1'b1, "R2");
    send_byte(ptr, 1'b1, "R8");
    do_start();  // repeated START, pointer kept (R8)
    send_byte({DEV, 1'b1}, 1'b1, "R8");
    for (int i = 0; i < n; i++) begin
      recv_byte(ref_mem[p], i != n - 1, req);
      p = (p + 1) % 256;
    end
    do_stop();
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i]     = 8'(i) ^ 8'hA5;
      ref_mem[i] = 8'(i) ^ 8'hA5;
    end
    wclk(5);
    rst_n = 1'b1;
    wclk(2);
    check(sda_oe == 1'b0, "R1", "sda_oe after reset", sda_oe, 0);
    check(reg_we == 1'b0, "R1", "reg_we after reset", reg_we, 0);
    wclk(10);

    // R5: pointer then three data bytes
    cur_req = "R5";
    write_seq(8'h10, 3, 8'h3C, "R5");
    // R6/R7/R8: read back, last byte NACKed
    read_seq(8'h10, 3, "R6");
    read_seq(8'h08, 10, "R6");

    // R3: foreign address
    cur_req = "R3";
    do_start();
    send_byte({7'h23, 1'b0}, 1'b0, "R3");
    send_byte(8'h10, 1'b0, "R3");
    send_byte(8'h77, 1'b0, "R3");
    do_stop();
    do_start();
    send_byte({7'h51, 1'b1}, 1'b0, "R3");
    do_stop();

    // R4: deselected, matching address
    cur_req = "R4";
    sel_n = 1'b1;
    wclk(6);
    do_start();
    send_byte({DEV, 1'b0}, 1'b0, "R4");
    send_byte(8'h10, 1'b0, "R4");
    send_byte(8'h99, 1'b0, "R4");
    do_stop();
    sel_n = 1'b0;
    wclk(6);
    read_seq(8'h10, 2, "R4");

    // R10: wrap across 0xFF
    cur_req = "R10";
    write_seq(8'hFE, 3, 8'h61, "R10");
    read_seq(8'hFE, 4, "R10");

    // R9: deselect in the middle of a read byte
    cur_req = "R9";
    do_start();
    send_byte({DEV, 1'b0}, 1'b1, "R9");
    send_byte(8'h20, 1'b1, "R9");
    do_start();
    send_byte({DEV, 1'b1}, 1'b1, "R9");
    recv_byte(ref_mem[8'h20], 1'b1, "R9");
    begin
      logic g;
      for (int i = 0; i < 3; i++) slot(1'b1, 1'b1, g);
      sel_n = 1'b1;
      wclk(4);
      check(sda_oe == 1'b0, "R9", "sda released after deselect", sda_oe, 0);
      may_drive = 1'b0;
      wclk(4);
      sel_n = 1'b0;
      wclk(6);
      for (int i = 0; i < 6; i++) slot(1'b1, 1'b0, g);
      check(g == 1'b1, "R9", "no ack slot drive after deselect", g, 1);
    end
    send_byte(8'h5A, 1'b0, "R9");
    do_stop();
    write_seq(8'h30, 2, 8'h0F, "R9");
    read_seq(8'h30, 2, "R9");

    wclk(20);
    check(exp_wr.size() == 0, "R5", "missing writes", exp_wr.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    if (!done) begin
      done = 1'b1;
      check(1'b0, "R1", "watchdog expired", cyc, 150000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule